// File: doc/BRIEF.md
# Eight-Bit Bidirectional Port with Per-Bit Drive Mode

This block is a general-purpose parallel port for a small processor register bus. It holds two registers. The first is an output value latch. The second is a per-bit drive-mode register that selects open-drain or push-pull drive for each bit. Both registers accept whole-byte writes and single-bit writes. Each register is reached at its own address on a shared address, write-enable and write-data bus. A write takes effect on the clock edge where it is presented.

Reads have two sources. A plain read of the data address returns the pin levels, sampled through a two-flop synchronizer. This holds even when a peripheral owns those pins. A read flagged as read-modify-write returns the latch instead, so that the processor changes the intended value and not what the wire shows. The processor then writes the modified value back with an ordinary write.

For each bit the block drives a tri-state pad with an enable and a value. A routing unit can take over any bit with an override value. Where that routed signal is a shared-bus or receive line, the routing unit can also force the bit to open-drain. A global weak pull-up control is on after reset, and an input can turn it off.

Top module: `gpio_port8`

## Requirements
- R1: After reset the latch holds all ones and the mode register holds all zeros. Every pad enable is low and the pull-up control output is high.
- R2: When the drive-mode bit is 0 (open-drain), an effective value of 1 releases the pin (enable low) and an effective value of 0 drives it low (enable high, value 0). An open-drain bit never drives high.
- R3: When the drive-mode bit is 1 (push-pull) and the bit is not forced to open-drain, the pin is always enabled and driven to its effective value.
- R4: A read with `rd_rmw`=0 at the data address returns the pad input levels as they were two clock edges earlier. This includes bits held by an override.
- R5: A read with `rd_rmw`=1 at the data address returns the latch contents, whatever the pins show.
- R6: A write with `bus_wr`=1 and `bus_bit`=0 loads all of `bus_wdata` into the addressed register (data address `DATA_ADDR`, default 0x00; mode address `MODE_ADDR`, default 0x01) on that clock edge.
- R7: A write with `bus_wr`=1 and `bus_bit`=1 loads `bus_wdata[0]` into the bit numbered `bus_bit_sel` of the addressed register. All other bits keep their values. This works for both registers.
- R8: A read at the mode address returns the drive-mode register.
- R9: When `ovr_en[i]`=1, `ovr_val[i]` takes the place of the latch bit as the effective value of pin i, and the drive-mode rules still apply.
- R10: When both `ovr_en[i]` and `ovr_od[i]` are 1, pin i is open-drain whatever its mode bit says. `ovr_od[i]` has no effect while `ovr_en[i]`=0.
- R11: `pad_pullup` is the inverse of `pu_dis`.
- R12: Writes to any other address change neither register, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_bit | input | 1 | 1 = single-bit write, 0 = byte write |
| bus_bit_sel | input | SW | Bit number for a single-bit write |
| bus_wdata | input | W | Write data (bit 0 used for single-bit writes) |
| rd_rmw | input | 1 | 1 = data read returns latch instead of pins |
| rd_data | output | W | Read data for the current address |
| ovr_en | input | W | Per-bit peripheral takeover |
| ovr_val | input | W | Peripheral output value per bit |
| ovr_od | input | W | Per-bit forced open-drain for routed signals |
| pu_dis | input | 1 | Global weak pull-up disable |
| pad_in | input | W | Pin levels seen at the pads |
| pad_oe | output | W | Pad output enable per bit |
| pad_out | output | W | Pad output value per bit |
| pad_pullup | output | 1 | Weak pull-up enable for all pads |

## Verification
The pad model resolves each pin from the port driver, an external driver or the pull-up. An external low pulled onto a released open-drain bit therefore separates the pin read path from the latch read path. The mode register is tried at all zeros, all ones and a mixed value. Override tests combine mixed modes with override values that differ from the latch, so the bench can tell the override value from the latch value. Forced open-drain is applied both with and without the matching override bit. Disabling the pull-up lets released pins float in the model, which separates pull-up behaviour from driven behaviour.

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] DATA_ADDR = AW'(0),
  parameter logic [AW-1:0] MODE_ADDR = AW'(1),
  localparam int unsigned SW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_bit,
  input  logic [SW-1:0] bus_bit_sel,
  input  logic [W-1:0]  bus_wdata,
  input  logic          rd_rmw,
  output logic [W-1:0]  rd_data,
  input  logic [W-1:0]  ovr_en,
  input  logic [W-1:0]  ovr_val,
  input  logic [W-1:0]  ovr_od,
  input  logic          pu_dis,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic          pad_pullup
);

  logic [W-1:0] latch_q, mode_q, sync1_q, sync2_q;
  logic [W-1:0] sel_mask, latch_nxt, mode_nxt, eff_val, od_sel;
  logic         hit_data, hit_mode;

  assign hit_data = (bus_addr == DATA_ADDR);
  assign hit_mode = (bus_addr == MODE_ADDR);
  assign sel_mask = W'(1) << bus_bit_sel;

  assign latch_nxt = bus_bit ? ((latch_q & ~sel_mask) | ({W{bus_wdata[0]}} & sel_mask))
                             : bus_wdata;
  assign mode_nxt  = bus_bit ? ((mode_q & ~sel_mask) | ({W{bus_wdata[0]}} & sel_mask))
                             : bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      mode_q  <= '0;
    end else if (bus_wr) begin
      if (hit_data) latch_q <= latch_nxt;
      if (hit_mode) mode_q  <= mode_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '1;
      sync2_q <= '1;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    if (hit_data)      rd_data = rd_rmw ? latch_q : sync2_q;
    else if (hit_mode) rd_data = mode_q;
    else               rd_data = '0;
  end

  assign eff_val = (ovr_en & ovr_val) | (~ovr_en & latch_q);
  assign od_sel  = ~mode_q | (ovr_en & ovr_od);

  for (genvar i = 0; i < W; i++) begin : g_drv
    assign pad_oe[i]  = od_sel[i] ? ~eff_val[i] : 1'b1;
    assign pad_out[i] = od_sel[i] ? 1'b0 : eff_val[i];
  end

  assign pad_pullup = ~pu_dis;

endmodule

module gpio_port8_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] DATA_ADDR = AW'(0),
  parameter logic [AW-1:0] MODE_ADDR = AW'(1),
  localparam int unsigned SW = (W > 1) ? $clog2(W) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_bit,
  input logic [SW-1:0] bus_bit_sel,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  ovr_en,
  input logic [W-1:0]  ovr_od,
  input logic [W-1:0]  latch_q,
  input logic [W-1:0]  mode_q,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_out
);

  logic [W-1:0] c_mask, c_forced;
  assign c_mask   = W'(1) << bus_bit_sel;
  assign c_forced = ovr_en & ovr_od;

  a_r1_reset_released: assert property (@(posedge clk) $rose(rst_n) |-> pad_oe == '0);

  a_r2_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mode_q | c_forced) & pad_oe & pad_out) == '0);

  a_r3_pp_always_on: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q & ~c_forced) & ~pad_oe) == '0);

  a_r6_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_bit && bus_addr == DATA_ADDR) |=> latch_q == $past(bus_wdata));

  a_r7_bit_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_bit && bus_addr == DATA_ADDR) |=>
      ((latch_q ^ $past(latch_q)) & ~$past(c_mask)) == '0);

  a_r12_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != DATA_ADDR && bus_addr != MODE_ADDR) |=>
      ($stable(latch_q) && $stable(mode_q)));

endmodule

bind gpio_port8 gpio_port8_chk #(.W(W), .AW(AW), .DATA_ADDR(DATA_ADDR), .MODE_ADDR(MODE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_bit(bus_bit),
  .bus_bit_sel(bus_bit_sel), .bus_wdata(bus_wdata), .ovr_en(ovr_en), .ovr_od(ovr_od),
  .latch_q(latch_q), .mode_q(mode_q), .pad_oe(pad_oe), .pad_out(pad_out)
);

// File: tb/test_gpio_port8.sv
`timescale 1ns/1ps
module test_gpio_port8;
  localparam logic [7:0] DA = 8'h00;
  localparam logic [7:0] MA = 8'h01;

  logic       clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, rd_data;
  logic       bus_wr = 0, bus_bit = 0, rd_rmw = 0, pu_dis = 0, pad_pullup;
  logic [2:0] bus_bit_sel = 0;
  logic [7:0] ovr_en = 0, ovr_val = 0, ovr_od = 0;
  logic [7:0] pad_in, pad_oe, pad_out, ext_en = 0, ext_val = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port8 i_gpio_port8 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_bit(bus_bit),
    .bus_bit_sel(bus_bit_sel), .bus_wdata(bus_wdata), .rd_rmw(rd_rmw), .rd_data(rd_data),
    .ovr_en(ovr_en), .ovr_val(ovr_val), .ovr_od(ovr_od), .pu_dis(pu_dis), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pullup(pad_pullup));

  // pad model: port driver, else external driver, else weak pull-up (floats low without it)
  always_comb
    for (int i = 0; i < 8; i++)
      pad_in[i] = pad_oe[i] ? pad_out[i] : ext_en[i] ? ext_val[i] : pad_pullup;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic b, input logic [2:0] s);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_bit = b; bus_bit_sel = s; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_bit = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic rmw, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; rd_rmw = rmw;
    #1 d = rd_data;
    rd_rmw = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 pullup", {7'b0, pad_pullup}, 8'h01);
    rd(DA, 1, d); chk("R1 latch", d, 8'hFF);
    rd(MA, 0, d); chk("R1/R8 mode", d, 8'h00);
    rd(DA, 0, d); chk("R4 pins pulled", d, 8'hFF);
  endtask

  task automatic t_open_drain();
    logic [7:0] d;
    wr(DA, 8'hA5, 0, 0);
    #1 chk("R2 oe", pad_oe, 8'h5A);
    chk("R2 out low", pad_out & pad_oe, 8'h00);
    settle(); rd(DA, 0, d); chk("R4 pins", d, 8'hA5);
    ext_en = 8'h01; ext_val = 8'h00;
    settle(); rd(DA, 0, d); chk("R4 wired low", d, 8'hA4);
    rd(DA, 1, d); chk("R5 rmw latch", d, 8'hA5);
    ext_en = 0;
  endtask

  task automatic t_push_pull();
    logic [7:0] d;
    wr(MA, 8'hFF, 0, 0);
    #1 chk("R3 oe", pad_oe, 8'hFF);
    chk("R3 out", pad_out, 8'hA5);
    rd(MA, 0, d); chk("R6/R8 mode", d, 8'hFF);
  endtask

  task automatic t_bit_write();
    logic [7:0] d;
    wr(DA, 8'h01, 1, 3); rd(DA, 1, d); chk("R7 set bit3", d, 8'hAD);
    wr(DA, 8'hFE, 1, 0); rd(DA, 1, d); chk("R7 clear bit0", d, 8'hAC);
    wr(MA, 8'h00, 1, 7); rd(MA, 0, d); chk("R7 mode bit7", d, 8'h7F);
  endtask

  task automatic t_override();
    logic [7:0] d;
    @(negedge clk); ovr_en = 8'h03; ovr_val = 8'h01;
    #1 chk("R9 oe", pad_oe, 8'h7F);
    chk("R9 out", pad_out & 8'h7F, 8'h2D);
    settle(); rd(DA, 0, d); chk("R4/R9 pins", d, 8'hAD);
    rd(DA, 1, d); chk("R5 latch under ovr", d, 8'hAC);
  endtask

  task automatic t_forced_od();
    @(negedge clk); ovr_od = 8'h03;
    #1 chk("R10 forced oe", pad_oe, 8'h7E);
    chk("R10 forced out", pad_out & 8'h03, 8'h00);
    @(negedge clk); ovr_od = 8'h0C;
    #1 chk("R10 od without ovr", pad_oe, 8'h7F);
    @(negedge clk); ovr_en = 0; ovr_od = 0; ovr_val = 0;
  endtask

  task automatic t_pullup();
    logic [7:0] d;
    wr(MA, 8'h00, 0, 0);
    wr(DA, 8'hFF, 0, 0);
    @(negedge clk); pu_dis = 1;
    #1 chk("R11 off", {7'b0, pad_pullup}, 8'h00);
    settle(); rd(DA, 0, d); chk("R11 float", d, 8'h00);
    rd(DA, 1, d); chk("R5 latch vs float", d, 8'hFF);
    @(negedge clk); pu_dis = 0;
    settle(); rd(DA, 0, d); chk("R11 on", d, 8'hFF);
  endtask

  task automatic t_foreign();
    logic [7:0] d;
    wr(8'h05, 8'h00, 0, 0);
    wr(8'h05, 8'h00, 1, 2);
    rd(DA, 1, d); chk("R12 latch kept", d, 8'hFF);
    rd(MA, 0, d); chk("R12 mode kept", d, 8'h00);
    rd(8'h05, 0, d); chk("R12 read zero", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_open_drain();
    t_push_pull();
    t_bit_write();
    t_override();
    t_forced_od();
    t_pullup();
    t_foreign();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule